// File: doc/BRIEF.md
# SAR ADC Conversion and Readout Sequencer

This block drives a serial-output successive-approximation converter from one fast master clock. It divides time into fixed frames counted in master-clock cycles. Each frame opens with a convert strobe. A short guard interval follows with all lines quiet. Then comes a burst of serial clock pulses during which the result bits are shifted in, most significant first. A second quiet interval closes the frame before the next strobe.

The serial clock is not free-running. It is the master clock passed through an enable that changes only while the master clock is low, so no pulse is ever cut short. No edge appears on the serial clock while the strobe is high or inside either guard interval, because clock activity near the sampling instant would corrupt the sample.

The default parameters give a 3-cycle strobe, a 1-cycle lead-in, 15 pulses and a 3-cycle tail: 22 cycles per frame. With a master clock near 110 MHz this is about 5 Msps and a 14-bit result. A frame is counted from cycle 0, the first cycle in which the strobe is high. FIRST = CNV_CYC + PRE_GAP is the cycle of the first pulse, and LAST = FIRST + NUM_PULSE - 1 is the cycle of the last one.

Top module: `sar_readout_seq`

## Requirements
- R1: While `run_i` stays high, successive rising edges of `cnv_o` are exactly CNV_CYC + PRE_GAP + NUM_PULSE + POST_GAP master cycles apart (22 with the defaults).
- R2: `cnv_o` is high for exactly CNV_CYC consecutive cycles in each frame, in cycles 0 to CNV_CYC-1.
- R3: After `cnv_o` falls, both `cnv_o` and `sclk_o` stay low for PRE_GAP full master cycles. The first serial pulse is in cycle FIRST.
- R4: Each frame carries exactly NUM_PULSE serial pulses, one in each of cycles FIRST to LAST. Each pulse is high during the high half of its master cycle.
- R5: After the last pulse falls, in the middle of cycle LAST, at least POST_GAP full master cycles pass before the next rising edge of `cnv_o`.
- R6: `sclk_o` is low whenever `cnv_o` is high, whenever the master clock is low, and in every cycle outside the pulse burst.
- R7: The bit on `sdo_i` at the rising edge of pulse k (k = 0 for the first pulse) becomes bit DATA_W-1-k of `data_o`, for k < DATA_W. Bits taken at later pulses are discarded. `data_o` changes only when `valid_o` is high.
- R8: `valid_o` is high for exactly one cycle per frame, in cycle LAST+1. That is also the first cycle in which `data_o` shows the new result.
- R9: A frame starts one cycle after the rising clock edge that samples `run_i` high while the block is idle or in the final cycle of a frame. If `run_i` is low at that point, the current frame completes, including its `valid_o`, and then `cnv_o`, `sclk_o` and `valid_o` stay low.
- R10: While `rst_ni` is low, `cnv_o`, `sclk_o` and `valid_o` are low and `data_o` is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Master clock; also the source of the serial clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| run_i | input | 1 | Keeps frames repeating while high |
| sdo_i | input | 1 | Serial data line from the converter |
| cnv_o | output | 1 | Convert strobe |
| sclk_o | output | 1 | Gated serial clock |
| data_o | output | DATA_W | Most recent result word |
| valid_o | output | 1 | One-cycle pulse marking a new result |

## Verification
The bench builds the block with DATA_W=6, NUM_PULSE=7, CNV_CYC=2, PRE_GAP=1 and POST_GAP=2. This gives a 12-cycle frame, so every cycle position of the frame is checked in every frame. An odd-multiplier sequence makes the converter model return each of the 64 possible 6-bit codes once across 64 back-to-back frames, which covers every bit pattern through the capture path. The run is also stopped and restarted: once just after a valid pulse, and once one cycle into a frame. This exercises the frame-completion rule and the restart from idle.

// File: rtl/sarseq_pkg.sv
`timescale 1ns/1ps
package sarseq_pkg;

    // Total master cycles in one conversion frame.
    function automatic int frame_len(int cnv_cyc, int pre_gap, int n_pulse, int post_gap);
        return cnv_cyc + pre_gap + n_pulse + post_gap;
    endfunction

    // Frame cycle index of the first serial pulse.
    function automatic int first_pulse(int cnv_cyc, int pre_gap);
        return cnv_cyc + pre_gap;
    endfunction

endpackage

// File: rtl/sarseq_timer.sv
`timescale 1ns/1ps
module sarseq_timer #(
    parameter int CNV_CYC   = 3,
    parameter int PRE_GAP   = 1,
    parameter int NUM_PULSE = 15,
    parameter int POST_GAP  = 3
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic run_i,
    output logic cnv_o,
    output logic burst_o,
    output logic start_o,
    output logic last_o
);
    localparam int FRAME = sarseq_pkg::frame_len(CNV_CYC, PRE_GAP, NUM_PULSE, POST_GAP);
    localparam int FIRST = sarseq_pkg::first_pulse(CNV_CYC, PRE_GAP);
    localparam int LAST  = FIRST + NUM_PULSE - 1;
    localparam int CW    = $clog2(FRAME + 1);

    typedef struct packed {
        logic          run;
        logic [CW-1:0] cnt;
        logic          cnv;
        logic          burst;   // a serial pulse is due in the next cycle
        logic          start;
        logic          last;
    } tmr_t;

    tmr_t s_d, s_q;
    int   ahead;

    always_comb begin
        s_d = s_q;
        if (!s_q.run) begin
            if (run_i) begin
                s_d.run = 1'b1;
                s_d.cnt = '0;
            end
        end else if (s_q.cnt == CW'(FRAME - 1)) begin
            s_d.cnt = '0;
            s_d.run = run_i;
        end else begin
            s_d.cnt = s_q.cnt + 1'b1;
        end
        ahead       = int'(s_d.cnt) + 1;
        s_d.cnv     = s_d.run && (int'(s_d.cnt) < CNV_CYC);
        s_d.burst   = s_d.run && (ahead >= FIRST) && (ahead <= LAST);
        s_d.start   = s_d.run && (s_d.cnt == '0);
        s_d.last    = s_d.run && (int'(s_d.cnt) == LAST);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            s_q     <= '0;
            s_q.cnt <= CW'(FRAME - 1);
        end else begin
            s_q <= s_d;
        end
    end

    assign cnv_o   = s_q.cnv;
    assign burst_o = s_q.burst;
    assign start_o = s_q.start;
    assign last_o  = s_q.last;

endmodule

// File: rtl/sarseq_clkgate.sv
`timescale 1ns/1ps
module sarseq_clkgate (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic en_i,
    output logic gate_o,
    output logic sclk_o
);
    logic gate_d, gate_q;

    always_comb gate_d = en_i;

    // Enable moves only on the falling edge, while the master clock is low.
    always_ff @(negedge clk_i or negedge rst_ni) begin
        if (!rst_ni) gate_q <= 1'b0;
        else         gate_q <= gate_d;
    end

    assign gate_o = gate_q;
    assign sclk_o = clk_i & gate_q;

endmodule

// File: rtl/sarseq_capture.sv
`timescale 1ns/1ps
module sarseq_capture #(
    parameter int DATA_W    = 14,
    parameter int NUM_PULSE = 15
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              start_i,
    input  logic              sample_i,
    input  logic              sdo_i,
    input  logic              publish_i,
    output logic [DATA_W-1:0] data_o,
    output logic              valid_o
);
    localparam int IW = $clog2(NUM_PULSE + 1);

    typedef struct packed {
        logic [IW-1:0]     idx;
        logic [DATA_W-1:0] shreg;
        logic [DATA_W-1:0] data;
        logic              valid;
    } cap_t;

    cap_t c_d, c_q;

    always_comb begin
        c_d       = c_q;
        c_d.valid = publish_i;
        if (start_i) begin
            c_d.idx = '0;
        end else if (sample_i) begin
            if (int'(c_q.idx) < DATA_W) begin
                c_d.shreg = {c_q.shreg[DATA_W-2:0], sdo_i};
            end
            c_d.idx = c_q.idx + 1'b1;
        end
        if (publish_i) begin
            c_d.data = c_q.shreg;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) c_q <= '0;
        else         c_q <= c_d;
    end

    assign data_o  = c_q.data;
    assign valid_o = c_q.valid;

    // The timer's publish point must follow exactly one sample per pulse.
    p_sample_count_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        publish_i |-> (int'(c_q.idx) == NUM_PULSE));

endmodule

// File: rtl/sar_readout_seq.sv
`timescale 1ns/1ps
module sar_readout_seq #(
    parameter int DATA_W    = 14,
    parameter int NUM_PULSE = 15,
    parameter int CNV_CYC   = 3,
    parameter int PRE_GAP   = 1,
    parameter int POST_GAP  = 3
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              run_i,
    input  logic              sdo_i,
    output logic              cnv_o,
    output logic              sclk_o,
    output logic [DATA_W-1:0] data_o,
    output logic              valid_o
);
    localparam int HW = $clog2(CNV_CYC + 2);
    localparam int PW = $clog2(NUM_PULSE + 2);

    logic burst, start, last, gate_en;

    sarseq_timer #(
        .CNV_CYC  (CNV_CYC),
        .PRE_GAP  (PRE_GAP),
        .NUM_PULSE(NUM_PULSE),
        .POST_GAP (POST_GAP)
    ) u_timer (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .run_i  (run_i),
        .cnv_o  (cnv_o),
        .burst_o(burst),
        .start_o(start),
        .last_o (last)
    );

    sarseq_clkgate u_gate (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .en_i  (burst),
        .gate_o(gate_en),
        .sclk_o(sclk_o)
    );

    sarseq_capture #(
        .DATA_W   (DATA_W),
        .NUM_PULSE(NUM_PULSE)
    ) u_cap (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .start_i  (start),
        .sample_i (burst),
        .sdo_i    (sdo_i),
        .publish_i(last),
        .data_o   (data_o),
        .valid_o  (valid_o)
    );

    // Checker state: strobe length and serial pulses seen since the strobe.
    logic [HW-1:0] hi_cnt_q;
    logic [PW-1:0] rise_cnt_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            hi_cnt_q   <= '0;
            rise_cnt_q <= '0;
        end else begin
            hi_cnt_q   <= cnv_o ? hi_cnt_q + 1'b1 : '0;
            rise_cnt_q <= cnv_o ? '0 : (gate_en ? rise_cnt_q + 1'b1 : rise_cnt_q);
        end
    end

    p_cnv_width_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(cnv_o) |-> (int'(hi_cnt_q) == CNV_CYC));

    p_sclk_quiet_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cnv_o |-> !gate_en);

    p_pulse_count_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        valid_o |-> (int'(rise_cnt_q) == NUM_PULSE));

    p_valid_single_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        valid_o |=> !valid_o);

    p_data_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$stable(data_o) |-> valid_o);

endmodule

// File: tb/tb_sar_readout_seq.sv
`timescale 1ns/1ps
module tb_sar_readout_seq;
    localparam int DW    = 6;
    localparam int NP    = 7;
    localparam int CNV   = 2;
    localparam int PRE   = 1;
    localparam int POST  = 2;
    localparam int FRAME = CNV + PRE + NP + POST;
    localparam int FIRST = CNV + PRE;
    localparam int LAST  = FIRST + NP - 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          run = 1'b0;
    logic          sdo;
    logic          cnv_o, sclk_o, valid_o;
    logic [DW-1:0] data_o;

    always #4 clk = ~clk;

    sar_readout_seq #(
        .DATA_W(DW), .NUM_PULSE(NP), .CNV_CYC(CNV), .PRE_GAP(PRE), .POST_GAP(POST)
    ) dut (
        .clk_i(clk), .rst_ni(rst_n), .run_i(run), .sdo_i(sdo),
        .cnv_o(cnv_o), .sclk_o(sclk_o), .data_o(data_o), .valid_o(valid_o)
    );

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    task automatic chk(bit ok, string req, int act, int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("test done: total=%0d bad=%0d", total, bad);
    endtask

    // Converter model: MSB ready at strobe rise, next bit after each sclk fall.
    function automatic logic [DW-1:0] word_of(int n);
        return DW'((n * 37 + 5) % (1 << DW));
    endfunction

    int            fno = -1;
    int            nfall = 0;
    logic [DW-1:0] word_cur = '0;

    always @(posedge cnv_o) begin
        fno++;
        word_cur = word_of(fno);
        nfall    = 0;
    end
    always @(negedge sclk_o) nfall++;
    assign sdo = (nfall < DW) ? word_cur[DW - 1 - nfall] : 1'b0;

    // Cycle monitor, sampled 1 ns after each rising master edge.
    int            fcyc = FRAME;
    bit            idle = 1'b1;
    bit            prev_c = 1'b0;
    int            nvalid = 0;
    logic [DW-1:0] held = '0;

    always @(posedge clk) begin
        #1;
        if (!rst_n) begin
            chk(cnv_o == 1'b0, "R10 cnv", int'(cnv_o), 0);
            chk(sclk_o == 1'b0, "R10 sclk", int'(sclk_o), 0);
            chk(valid_o == 1'b0, "R10 valid", int'(valid_o), 0);
            chk(data_o == '0, "R10 data", int'(data_o), 0);
            prev_c = 1'b0;
        end else begin
            bit ec, es, ev;
            string rq;
            if (cnv_o && !prev_c) begin
                if (!idle) chk(fcyc == FRAME - 1, "R1 period", fcyc + 1, FRAME);
                fcyc = 0;
                idle = 1'b0;
            end else if (!idle) begin
                fcyc++;
            end
            if (!idle && fcyc >= FRAME) idle = 1'b1;
            ec = !idle && (fcyc < CNV);
            es = !idle && (fcyc >= FIRST) && (fcyc <= LAST);
            ev = !idle && (fcyc == LAST + 1);
            chk(cnv_o == ec, idle ? "R9 cnv idle" : "R2 cnv", int'(cnv_o), int'(ec));
            if (idle)             rq = "R9 sclk idle";
            else if (ec)          rq = "R6 sclk under cnv";
            else if (fcyc < FIRST) rq = "R3 lead gap";
            else if (fcyc > LAST) rq = "R5 tail gap";
            else                  rq = "R4 pulse";
            chk(sclk_o == es, rq, int'(sclk_o), int'(es));
            chk(valid_o == ev, idle ? "R9 valid idle" : "R8 valid", int'(valid_o), int'(ev));
            if (valid_o) begin
                chk(data_o == word_cur, "R7 result", int'(data_o), int'(word_cur));
                held = word_cur;
                nvalid++;
            end else begin
                chk(data_o == held, "R7 hold", int'(data_o), int'(held));
            end
            prev_c = cnv_o;
        end
    end

    // The serial clock must be low in every low phase of the master clock.
    always @(negedge clk) begin
        #1;
        chk(sclk_o == 1'b0, "R6 low phase", int'(sclk_o), 0);
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        run = 1'b1;
        wait (nvalid >= 64);          // every 6-bit code once
        @(negedge clk);
        run = 1'b0;                   // drop just after a valid pulse
        repeat (3 * FRAME) @(negedge clk);
        chk(nvalid == 64, "R9 stop count", nvalid, 64);
        run = 1'b1;
        @(posedge cnv_o);
        @(negedge clk);
        run = 1'b0;                   // drop one cycle into a frame
        repeat (3 * FRAME) @(negedge clk);
        chk(nvalid == 65, "R9 single frame", nvalid, 65);
        run = 1'b1;
        wait (nvalid >= 68);
        @(negedge clk);
        run = 1'b0;
        repeat (2 * FRAME) @(negedge clk);
        chk(nvalid == 68, "R1 restart count", nvalid, 68);
        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL R1 watchdog: actual=%0d expected=%0d", nvalid, 68);
            summary();
            $finish;
        end
    end

endmodule